// File: doc/BRIEF.md
# Speed-Scaled Out-of-Band Burst Generator

This block drives the out-of-band signalling patterns of a serial storage link transmitter: the host reset request, the device initialisation request and the wake request. Each pattern is six bursts of ALIGN primitive dwords, and every burst is followed by an electrical-idle gap. The gap length tells the receiver which pattern it is seeing: reset and init use a long gap, and wake uses a short gap that is about as long as a burst.

The receiver measures a burst in time, not in primitives. The generator therefore scales the number of ALIGN dwords per burst with the link generation. A burst is 4 dwords at Gen1, 8 at Gen2 and 16 at Gen3. A dword lasts `DW_CLKS_G1` clocks at Gen1, half that at Gen2 and a quarter at Gen3. The burst time in clocks is therefore the same at every speed. Gap lengths come from two inputs given in Gen1 dwords, nominally 12 for the long gap and 4 for the short gap. These are scaled the same way. Both gap inputs must be at least one.

The caller gives a pattern type, a generation code and the host/device role, then strobes `start`. The block asserts `tx_align` for each burst dword and pulses `dw_stb` at every dword boundary. When the pattern ends it pulses `done`. Serialisation, line coding and squelch detection are handled elsewhere.

Top module: `oob_burst_gen`

## Requirements
- R1: A burst holds 4 ALIGN dwords at Gen1 (`gen`=0), 8 at Gen2 (`gen`=1) and 16 at Gen3 (`gen`=2). A dword lasts 4 clocks at Gen1, 2 at Gen2 and 1 at Gen3. `dw_stb` pulses for one clock in the first clock of every dword, both burst and gap, while a pattern runs.
- R2: Each burst keeps `tx_align` high for exactly 16 consecutive clocks at every generation.
- R3: Reset (`sig_type`=0) and init (`sig_type`=1) patterns use a gap of `cfg_long_gap` << `gen` dwords. Wake (`sig_type`=2) uses `cfg_short_gap` << `gen` dwords. With the gap inputs at 12 and 4, a reset or init pattern lasts 384 clocks and a wake pattern lasts 192 clocks.
- R4: A pattern is six bursts, each followed by one gap. `busy` and `tx_align` rise in the clock after the `start` edge, and `busy` stays high for exactly 6·(16 + 4·gap) clocks, where gap is the selected gap input value.
- R5: A request is illegal when it is a reset with `host_mode`=0, an init with `host_mode`=1, `sig_type`=3 or `gen`=3. An illegal request pulses `err` for one clock, and `busy`, `tx_align` and `dw_stb` stay low.
- R6: A `start` while `busy` is high is ignored. It raises no `err` and does not change the running pattern. The pattern type, generation and gap values are captured at the accepted `start`.
- R7: `done` pulses for one clock in the first clock after the final gap, which is the same clock in which `busy` falls.
- R8: After reset, `tx_align`, `dw_stb`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| start | input | 1 | Request strobe |
| sig_type | input | 2 | 0 reset, 1 init, 2 wake, 3 reserved |
| gen | input | 2 | 0 Gen1, 1 Gen2, 2 Gen3, 3 reserved |
| cfg_long_gap | input | CFG_W | Long gap in Gen1 dwords |
| cfg_short_gap | input | CFG_W | Short gap in Gen1 dwords |
| tx_align | output | 1 | High while an ALIGN dword is sent, low means idle |
| dw_stb | output | 1 | First clock of each dword |
| busy | output | 1 | Pattern in progress |
| done | output | 1 | One-clock end-of-pattern pulse |
| err | output | 1 | One-clock illegal-request pulse |

## Verification
The hardest case to reach is a new request arriving in the middle of a running pattern. It must be dropped without affecting the sequence. Dropping it means the error path must also stay silent, even though the dropped request would be illegal if it had been accepted. The bench waits until the 50th clock of a Gen1 reset pattern. It then strobes an illegal init request and also shrinks the long-gap input. The expected bench result is that the pattern length, burst count and strobe count all match the values captured at the original request, and that no `err` appears.

// File: rtl/oob_burst_pkg.sv
package oob_burst_pkg;
    typedef enum logic [1:0] {
        SIG_RESET = 2'd0,
        SIG_INIT  = 2'd1,
        SIG_WAKE  = 2'd2,
        SIG_RSVD  = 2'd3
    } oob_sig_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BURST = 2'd1,
        PH_GAP   = 2'd2
    } oob_phase_e;

    localparam int unsigned GEN_MAX = 2;  // highest legal generation code
endpackage

// File: rtl/oob_req_decode.sv
module oob_req_decode
    import oob_burst_pkg::*;
#(
    parameter int unsigned CFG_W      = 8,
    parameter int unsigned ALIGN_G1   = 4,
    parameter int unsigned DW_CLKS_G1 = 4,
    localparam int unsigned DW_W      = CFG_W + 2,
    localparam int unsigned CK_W      = $clog2(DW_CLKS_G1 + 1)
) (
    input  logic             host_mode,
    input  logic [1:0]       sig_type,
    input  logic [1:0]       gen,
    input  logic [CFG_W-1:0] cfg_long_gap,
    input  logic [CFG_W-1:0] cfg_short_gap,
    output logic             legal,
    output logic [DW_W-1:0]  burst_dw,
    output logic [DW_W-1:0]  gap_dw,
    output logic [CK_W-1:0]  dw_clks
);
    oob_sig_e sig;
    logic     role_ok;
    logic     gen_ok;

    always_comb begin
        sig = oob_sig_e'(sig_type);
        gen_ok = (32'(gen) <= GEN_MAX);
        unique case (sig)
            SIG_RESET: role_ok = host_mode;
            SIG_INIT:  role_ok = !host_mode;
            SIG_WAKE:  role_ok = 1'b1;
            default:   role_ok = 1'b0;
        endcase
        legal    = role_ok && gen_ok;
        burst_dw = DW_W'(ALIGN_G1) << gen;
        gap_dw   = ((sig == SIG_WAKE) ? DW_W'(cfg_short_gap) : DW_W'(cfg_long_gap)) << gen;
        dw_clks  = CK_W'(DW_CLKS_G1 >> gen);
    end
endmodule

// File: rtl/oob_seq.sv
module oob_seq
    import oob_burst_pkg::*;
#(
    parameter int unsigned DW_W       = 10,
    parameter int unsigned CK_W       = 3,
    parameter int unsigned NUM_BURSTS = 6,
    localparam int unsigned BC_W      = $clog2(NUM_BURSTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            legal,
    input  logic [DW_W-1:0] burst_dw,
    input  logic [DW_W-1:0] gap_dw,
    input  logic [CK_W-1:0] dw_clks,
    output logic            tx_align,
    output logic            dw_stb,
    output logic            busy,
    output logic            done,
    output logic            err
);
    typedef struct packed {
        oob_phase_e      phase;
        logic [CK_W-1:0] clk_left;
        logic [DW_W-1:0] dw_left;
        logic [BC_W-1:0] bursts_left;
        logic [DW_W-1:0] burst_len;
        logic [DW_W-1:0] gap_len;
        logic [CK_W-1:0] clks_per_dw;
        logic            stb;
        logic            done;
        logic            err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.stb  = 1'b0;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                if (legal) begin
                    s_d.phase       = PH_BURST;
                    s_d.burst_len   = burst_dw;
                    s_d.gap_len     = gap_dw;
                    s_d.clks_per_dw = dw_clks;
                    s_d.clk_left    = dw_clks - 1'b1;
                    s_d.dw_left     = burst_dw - 1'b1;
                    s_d.bursts_left = BC_W'(NUM_BURSTS - 1);
                    s_d.stb         = 1'b1;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end else if (s_q.clk_left != '0) begin
            s_d.clk_left = s_q.clk_left - 1'b1;
        end else begin
            s_d.clk_left = s_q.clks_per_dw - 1'b1;
            s_d.stb      = 1'b1;
            if (s_q.dw_left != '0) begin
                s_d.dw_left = s_q.dw_left - 1'b1;
            end else if (s_q.phase == PH_BURST) begin
                s_d.phase   = PH_GAP;
                s_d.dw_left = s_q.gap_len - 1'b1;
            end else if (s_q.bursts_left != '0) begin
                s_d.phase       = PH_BURST;
                s_d.dw_left     = s_q.burst_len - 1'b1;
                s_d.bursts_left = s_q.bursts_left - 1'b1;
            end else begin
                s_d.phase = PH_IDLE;
                s_d.stb   = 1'b0;
                s_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_align = (s_q.phase == PH_BURST);
    assign busy     = (s_q.phase != PH_IDLE);
    assign dw_stb   = s_q.stb;
    assign done     = s_q.done;
    assign err      = s_q.err;
endmodule

// File: rtl/oob_burst_gen.sv
module oob_burst_gen
    import oob_burst_pkg::*;
#(
    parameter int unsigned CFG_W      = 8,
    parameter int unsigned ALIGN_G1   = 4,
    parameter int unsigned DW_CLKS_G1 = 4,
    parameter int unsigned NUM_BURSTS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic             start,
    input  logic [1:0]       sig_type,
    input  logic [1:0]       gen,
    input  logic [CFG_W-1:0] cfg_long_gap,
    input  logic [CFG_W-1:0] cfg_short_gap,
    output logic             tx_align,
    output logic             dw_stb,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int unsigned DW_W = CFG_W + 2;
    localparam int unsigned CK_W = $clog2(DW_CLKS_G1 + 1);

    logic            legal;
    logic [DW_W-1:0] burst_dw;
    logic [DW_W-1:0] gap_dw;
    logic [CK_W-1:0] dw_clks;

    oob_req_decode #(
        .CFG_W      (CFG_W),
        .ALIGN_G1   (ALIGN_G1),
        .DW_CLKS_G1 (DW_CLKS_G1)
    ) u_dec (
        .host_mode     (host_mode),
        .sig_type      (sig_type),
        .gen           (gen),
        .cfg_long_gap  (cfg_long_gap),
        .cfg_short_gap (cfg_short_gap),
        .legal         (legal),
        .burst_dw      (burst_dw),
        .gap_dw        (gap_dw),
        .dw_clks       (dw_clks)
    );

    oob_seq #(
        .DW_W       (DW_W),
        .CK_W       (CK_W),
        .NUM_BURSTS (NUM_BURSTS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .legal    (legal),
        .burst_dw (burst_dw),
        .gap_dw   (gap_dw),
        .dw_clks  (dw_clks),
        .tx_align (tx_align),
        .dw_stb   (dw_stb),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );
endmodule

// File: rtl/oob_burst_gen_chk.sv
module oob_burst_gen_chk #(
    parameter int unsigned BURST_CLKS = 16,
    localparam int unsigned RUN_W     = $clog2(BURST_CLKS + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tx_align,
    input logic dw_stb,
    input logic busy,
    input logic done,
    input logic err
);
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tx_align) begin
            run_q <= (run_q == {RUN_W{1'b1}}) ? run_q : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_BURST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_align) |-> (run_q == RUN_W'(BURST_CLKS))); // R2
    AST_ALIGN_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_align |-> busy); // R4
    AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dw_stb |-> busy); // R1
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !tx_align)); // R5
    AST_NO_ERR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

bind oob_burst_gen oob_burst_gen_chk #(
    .BURST_CLKS (ALIGN_G1 * DW_CLKS_G1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_align (tx_align),
    .dw_stb   (dw_stb),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/oob_burst_gen_tb.sv
module oob_burst_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b0;
    logic       start = 1'b0;
    logic [1:0] sig_type = 2'd0;
    logic [1:0] gen = 2'd0;
    logic [7:0] cfg_long_gap = 8'd12;
    logic [7:0] cfg_short_gap = 8'd4;
    logic       tx_align, dw_stb, busy, done, err;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    oob_burst_gen u_dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .start(start),
        .sig_type(sig_type), .gen(gen), .cfg_long_gap(cfg_long_gap),
        .cfg_short_gap(cfg_short_gap), .tx_align(tx_align), .dw_stb(dw_stb),
        .busy(busy), .done(done), .err(err)
    );

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  gn;
        logic        host;
        logic [7:0]  lgap;
        logic [7:0]  sgap;
        logic        exp_err;
        logic [15:0] exp_len;
        logic [15:0] exp_stb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b1, 8'd12, 8'd4, 1'b0, 16'd384, 16'd96},
        '{2'd0, 2'd1, 1'b1, 8'd12, 8'd4, 1'b0, 16'd384, 16'd192},
        '{2'd1, 2'd2, 1'b0, 8'd12, 8'd4, 1'b0, 16'd384, 16'd384},
        '{2'd2, 2'd0, 1'b1, 8'd12, 8'd4, 1'b0, 16'd192, 16'd48},
        '{2'd2, 2'd1, 1'b0, 8'd12, 8'd4, 1'b0, 16'd192, 16'd96},
        '{2'd2, 2'd2, 1'b1, 8'd12, 8'd4, 1'b0, 16'd192, 16'd192},
        '{2'd0, 2'd1, 1'b1, 8'd10, 8'd4, 1'b0, 16'd336, 16'd168},
        '{2'd0, 2'd0, 1'b0, 8'd12, 8'd4, 1'b1, 16'd0,   16'd0},
        '{2'd1, 2'd1, 1'b1, 8'd12, 8'd4, 1'b1, 16'd0,   16'd0},
        '{2'd2, 2'd3, 1'b1, 8'd12, 8'd4, 1'b1, 16'd0,   16'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Applies one request; poke_k > 0 strobes a second request mid-run.
    task automatic run(input vec_t v, input int poke_k,
                       output int busy_n, output int align_n, output int stb_n,
                       output int bursts, output int first_len, output int done_k,
                       output int err_n, output int first_busy_k);
        bit prev_align = 1'b0;
        bit first_done = 1'b0;
        busy_n = 0; align_n = 0; stb_n = 0; bursts = 0; first_len = 0;
        done_k = 0; err_n = 0; first_busy_k = 0;
        @(negedge clk);
        sig_type = v.st; gen = v.gn; host_mode = v.host;
        cfg_long_gap = v.lgap; cfg_short_gap = v.sgap;
        start = 1'b1;
        for (int k = 1; k < 2000; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke_k > 0 && k == poke_k) begin
                start = 1'b1; sig_type = 2'd1; host_mode = 1'b1; cfg_long_gap = 8'd2;
            end
            if (poke_k > 0 && k == poke_k + 1) start = 1'b0;
            if (busy) begin
                busy_n++;
                if (first_busy_k == 0) first_busy_k = k;
            end
            if (tx_align) begin
                align_n++;
                if (!first_done) first_len++;
            end
            if (prev_align && !tx_align) first_done = 1'b1;
            if (tx_align && !prev_align) bursts++;
            prev_align = tx_align;
            if (dw_stb) stb_n++;
            if (err) err_n++;
            if (done) begin
                done_k = k;
                break;
            end
            if (k > 3 && !busy) break;
        end
        cfg_long_gap = 8'd12;
    endtask

    initial begin
        #2_000_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int bn, an, sn, bu, fl, dk, en, fb;
        vec_t w;
        repeat (3) @(negedge clk);
        // R8: reset state
        check({tx_align, dw_stb, busy, done, err} == 5'b0, "R8 reset outputs",
              int'({tx_align, dw_stb, busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({tx_align, dw_stb, busy, done, err} == 5'b0, "R8 idle after reset",
              int'({tx_align, dw_stb, busy, done, err}), 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 0, bn, an, sn, bu, fl, dk, en, fb);
            if (VECS[i].exp_err) begin
                check(en == 1, "R5 err pulse count", en, 1);
                check(bn == 0 && an == 0 && sn == 0, "R5 nothing sent", bn + an + sn, 0);
            end else begin
                check(en == 0, "R5 no err on legal", en, 0);
                check(fb == 1, "R4 busy starts after start edge", fb, 1);
                check(bn == int'(VECS[i].exp_len), "R3 R4 pattern length", bn, int'(VECS[i].exp_len));
                check(bu == 6, "R4 burst count", bu, 6);
                check(an == 96, "R2 total align clocks", an, 96);
                check(fl == 16, "R2 first burst width", fl, 16);
                check(sn == int'(VECS[i].exp_stb), "R1 dword strobes", sn, int'(VECS[i].exp_stb));
                check(dk == int'(VECS[i].exp_len) + 1, "R7 done timing", dk, int'(VECS[i].exp_len) + 1);
            end
        end

        // R7: done is a single clock and busy is low alongside
        @(negedge clk);
        check(!done && !busy, "R7 done single pulse", int'(done), 0);

        // R6: illegal request and gap change mid-run must be ignored
        w = VECS[0];
        run(w, 50, bn, an, sn, bu, fl, dk, en, fb);
        check(en == 0, "R6 no err while busy", en, 0);
        check(bn == 384, "R6 length unchanged", bn, 384);
        check(sn == 96, "R6 strobes unchanged", sn, 96);
        check(bu == 6, "R6 bursts unchanged", bu, 6);

        // R5: reserved pattern type
        w = VECS[0];
        w.st = 2'd3;
        run(w, 0, bn, an, sn, bu, fl, dk, en, fb);
        check(en == 1 && bn == 0, "R5 reserved type rejected", en * 1000 + bn, 1000);

        // R3: wake with a custom short gap at Gen3, gap 6 -> 6*(16+24)=240
        w = VECS[5];
        w.sgap = 8'd6;
        run(w, 0, bn, an, sn, bu, fl, dk, en, fb);
        check(bn == 240, "R3 custom short gap", bn, 240);
        check(sn == 6 * (16 + 24), "R1 strobes at Gen3 custom gap", sn, 240);

        summary();
    end
endmodule